// File: doc/BRIEF.md
# Touch Digitizer ADC Controller

This block reads the position of a touch from a 12-bit touch-screen converter. It watches the converter's active-low pen-down line. When a touch is seen, it asks a shared-bus arbiter for the serial pins. Once the grant arrives it runs one X conversion and then one Y conversion. It then presents both coordinates together with a one-cycle valid strobe. The serial clock and chip-enable pins are shared with a display register port. For that reason the block drives the shared pins only while it holds the grant. The chip enable reaches the converter through an inverter, so the block raises the pin to select the converter.

Each conversion is a frame of 24 serial clocks. The first 8 clocks shift a control byte out on the data-in line. The next clock is the converter's busy slot. The 12 clocks after that carry the result, most significant bit first. If the busy line is not seen at the start of the result window, that conversion is run again, up to a parameterised number of retries. After a read, a new read needs the pen line to be seen released, or a parameterised repeat interval to pass while the pen stays down.

Top module: `touch_adc_ctrl`

## Requirements
- R1: During and right after reset, bus_req, sif_oe, sif_sce, sif_dclk, sif_din and coord_valid are low, and coord_x and coord_y are zero.
- R2: pen_irq_n passes through two synchronising flops, so bus_req rises on the third clock edge after pen_irq_n goes low. bus_req never rises while pen_irq_n stays high.
- R3: sif_oe is high only while bus_req and bus_gnt are both high. While sif_oe is low, sif_sce, sif_dclk and sif_din are low. While sif_oe is high, sif_sce is high, which selects the converter through the inverting chip-enable path.
- R4: Each frame sends a control byte on sif_din, most significant bit first, one bit per sif_dclk rising edge. Bit 7 is the start bit, always 1. Bits 6..4 are the channel code. Bit 3 is the resolution bit, always 0 (12-bit). Bit 2 is SER_DFR. Bits 1..0 are PD_BITS. sif_din changes only on falling edges of sif_dclk.
- R5: Every conversion frame has exactly 24 sif_dclk rising edges. sif_dclk is high for HALF_DIV clock cycles and low for HALF_DIV clock cycles.
- R6: Clock slots are numbered from 0, where slot 0 is the start bit. The result is the 12 adc_dout values sampled at the rising edges of slots 9 to 20, most significant bit first.
- R7: Under one grant, the X conversion (channel code X_CH, default 3'b101) completes before the Y conversion (channel code Y_CH, default 3'b001).
- R8: After a good Y conversion, coord_valid is high for exactly one cycle. In that same cycle bus_req and sif_oe fall, and coord_x and coord_y take the new values. At all other times the coordinates hold their values.
- R9: After a read ends, no new read starts until the synchronised pen line has been seen high, or until REPEAT_CYC cycles have passed with the pen still down.
- R10: adc_busy is sampled at the rising edge of slot 9. If it is low, the conversion on the same channel is run again and no result is taken from that frame.
- R11: If a channel fails 1+MAX_RETRY attempts in a row, the read is abandoned. bus_req falls, no coord_valid is issued, coord_x and coord_y keep their values, and the rule of R9 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pen_irq_n | input | 1 | Pen-down line from the converter, low while touched |
| bus_req | output | 1 | Request for the shared serial pins |
| bus_gnt | input | 1 | Grant of the shared serial pins from the arbiter |
| sif_oe | output | 1 | Drive enable for the shared pins |
| sif_sce | output | 1 | Shared chip-enable pin, high selects the converter |
| sif_dclk | output | 1 | Shared serial clock |
| sif_din | output | 1 | Serial control data to the converter |
| adc_dout | input | 1 | Serial result data from the converter |
| adc_busy | input | 1 | Converter busy indication |
| coord_x | output | 12 | Last X coordinate |
| coord_y | output | 12 | Last Y coordinate |
| coord_valid | output | 1 | One-cycle strobe when new coordinates are present |

## Verification
The hardest situations to reach are the retry and abandon paths. A real converter always raises busy, so these paths are never exercised by normal traffic. The bench's converter model can withhold busy for a chosen number of frames, which forces one retry in one touch and exhausts every attempt in another. In each case the bench counts the frames seen on the pins and watches the coordinates. The repeat interval is also hard to reach: the bench holds the pen down across two full reads and measures the gap between the two strobes, then compares it against a quick release and re-press.

// File: rtl/tadc_pkg.sv
`timescale 1ns/1ps
package tadc_pkg;
   localparam int CTRL_BITS  = 8;
   localparam int RES_BITS   = 12;
   localparam int FRAME_CLKS = 24;
   localparam int DATA_FIRST = CTRL_BITS + 1;
   localparam int DATA_LAST  = DATA_FIRST + RES_BITS - 1;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_LEAD,
      ST_CONV
   } tadc_state_e;

   // start bit, channel, 12-bit mode, reference select, power bits
   function automatic logic [CTRL_BITS-1:0] make_ctrl(input logic [2:0] ch,
                                                      input logic       ser,
                                                      input logic [1:0] pd);
      return {1'b1, ch, 1'b0, ser, pd};
   endfunction
endpackage

// File: rtl/tadc_pen_arm.sv
`timescale 1ns/1ps
module tadc_pen_arm #(
   parameter int SYNC_STAGES = 2,
   parameter int REPEAT_CYC  = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pen_irq_n,
   input  logic consume,
   output logic pen_down,
   output logic armed
);
   localparam int RW = $clog2(REPEAT_CYC + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [RW-1:0]          rpt_q;
   logic                   armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pen_irq_n};
   end

   assign pen_down = ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         rpt_q   <= '0;
      end else if (consume) begin
         armed_q <= 1'b0;
         rpt_q   <= '0;
      end else if (!pen_down) begin
         armed_q <= 1'b1;
         rpt_q   <= '0;
      end else if (!armed_q) begin
         if (rpt_q == RW'(REPEAT_CYC - 1)) begin
            armed_q <= 1'b1;
            rpt_q   <= '0;
         end else begin
            rpt_q <= rpt_q + 1'b1;
         end
      end
   end

   assign armed = armed_q;
endmodule

// File: rtl/tadc_dclk_gen.sv
`timescale 1ns/1ps
module tadc_dclk_gen #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic dclk,
   output logic rise_now,
   output logic fall_now
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [CW-1:0] cnt_q;
   logic          lvl_q;
   logic          half_done;

   assign half_done = run && (cnt_q == CW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (half_done) begin
         cnt_q <= '0;
         lvl_q <= ~lvl_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign dclk     = lvl_q;
   assign rise_now = half_done && !lvl_q;
   assign fall_now = half_done && lvl_q;
endmodule

// File: rtl/tadc_frame.sv
`timescale 1ns/1ps
module tadc_frame import tadc_pkg::*; #(
   parameter int BUSY_CHECK = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CTRL_BITS-1:0] ctrl,
   input  logic                 rise_now,
   input  logic                 fall_now,
   input  logic                 dout,
   input  logic                 busy,
   output logic                 active,
   output logic                 din,
   output logic                 done,
   output logic                 ok,
   output logic [RES_BITS-1:0]  result
);
   localparam int IW = $clog2(FRAME_CLKS);

   logic                active_q;
   logic [IW-1:0]       idx_q;
   logic [RES_BITS-1:0] sh_q;
   logic                done_q;
   logic                in_data;
   logic                launch;

   assign launch  = start && !active_q;
   assign in_data = (idx_q >= IW'(DATA_FIRST)) && (idx_q <= IW'(DATA_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         sh_q     <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (launch) begin
            active_q <= 1'b1;
            idx_q    <= '0;
         end else if (active_q) begin
            if (rise_now && in_data)
               sh_q <= {sh_q[RES_BITS-2:0], dout};
            if (fall_now) begin
               if (idx_q == IW'(FRAME_CLKS - 1)) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end
   end

   generate
      if (BUSY_CHECK != 0) begin : g_busy
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               seen_q <= 1'b0;
            else if (launch)
               seen_q <= 1'b0;
            else if (active_q && rise_now && idx_q == IW'(DATA_FIRST))
               seen_q <= busy;
         end
         assign ok = seen_q;
      end else begin : g_nobusy
         assign ok = 1'b1;
      end
   endgenerate

   assign din    = (active_q && idx_q < IW'(CTRL_BITS)) ?
                   ctrl[3'(CTRL_BITS - 1) - idx_q[2:0]] : 1'b0;
   assign active = active_q;
   assign done   = done_q;
   assign result = sh_q;
endmodule

// File: rtl/touch_adc_ctrl.sv
`timescale 1ns/1ps
module touch_adc_ctrl import tadc_pkg::*; #(
   parameter int         HALF_DIV    = 4,
   parameter int         REPEAT_CYC  = 500000,
   parameter int         MAX_RETRY   = 3,
   parameter int         BUSY_CHECK  = 1,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] X_CH        = 3'b101,
   parameter logic [2:0] Y_CH        = 3'b001,
   parameter logic       SER_DFR     = 1'b0,
   parameter logic [1:0] PD_BITS     = 2'b00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pen_irq_n,
   output logic                bus_req,
   input  logic                bus_gnt,
   output logic                sif_oe,
   output logic                sif_sce,
   output logic                sif_dclk,
   output logic                sif_din,
   input  logic                adc_dout,
   input  logic                adc_busy,
   output logic [RES_BITS-1:0] coord_x,
   output logic [RES_BITS-1:0] coord_y,
   output logic                coord_valid
);
   localparam int RTW = $clog2(MAX_RETRY + 1) + 1;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (REPEAT_CYC < 2) begin : g_bad_rpt
         $error("REPEAT_CYC must be at least 2");
      end
      if (MAX_RETRY < 0) begin : g_bad_retry
         $error("MAX_RETRY must not be negative");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (X_CH == Y_CH) begin : g_bad_ch
         $error("X_CH and Y_CH must differ");
      end
   endgenerate

   tadc_state_e         state_q;
   logic                req_q;
   logic                oe_q;
   logic                chan_y_q;
   logic [RTW-1:0]      retry_q;
   logic                start_q;
   logic [RES_BITS-1:0] x_hold_q;
   logic [RES_BITS-1:0] x_q;
   logic [RES_BITS-1:0] y_q;
   logic                valid_q;

   logic                pen_down;
   logic                armed;
   logic                consume;
   logic                frm_active;
   logic                frm_din;
   logic                frm_done;
   logic                frm_ok;
   logic [RES_BITS-1:0] frm_result;
   logic                dclk;
   logic                rise_now;
   logic                fall_now;
   logic                read_good;
   logic                read_lost;
   logic [CTRL_BITS-1:0] ctrl_byte;

   tadc_pen_arm #(
      .SYNC_STAGES(SYNC_STAGES),
      .REPEAT_CYC (REPEAT_CYC)
   ) u_pen (
      .clk      (clk),
      .rst_n    (rst_n),
      .pen_irq_n(pen_irq_n),
      .consume  (consume),
      .pen_down (pen_down),
      .armed    (armed)
   );

   tadc_dclk_gen #(
      .HALF_DIV(HALF_DIV)
   ) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (frm_active),
      .dclk    (dclk),
      .rise_now(rise_now),
      .fall_now(fall_now)
   );

   assign ctrl_byte = make_ctrl(chan_y_q ? Y_CH : X_CH, SER_DFR, PD_BITS);

   tadc_frame #(
      .BUSY_CHECK(BUSY_CHECK)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_q),
      .ctrl    (ctrl_byte),
      .rise_now(rise_now),
      .fall_now(fall_now),
      .dout    (adc_dout),
      .busy    (adc_busy),
      .active  (frm_active),
      .din     (frm_din),
      .done    (frm_done),
      .ok      (frm_ok),
      .result  (frm_result)
   );

   assign read_good = frm_done && frm_ok && chan_y_q;
   assign read_lost = frm_done && !frm_ok && (retry_q == RTW'(MAX_RETRY));
   assign consume   = (state_q == ST_CONV) && (read_good || read_lost);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         req_q    <= 1'b0;
         oe_q     <= 1'b0;
         chan_y_q <= 1'b0;
         retry_q  <= '0;
         start_q  <= 1'b0;
         x_hold_q <= '0;
         x_q      <= '0;
         y_q      <= '0;
         valid_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (pen_down && armed) begin
                  req_q   <= 1'b1;
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (bus_gnt) begin
                  oe_q     <= 1'b1;
                  chan_y_q <= 1'b0;
                  retry_q  <= '0;
                  state_q  <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               start_q <= 1'b1;
               state_q <= ST_CONV;
            end
            ST_CONV: begin
               if (consume) begin
                  req_q   <= 1'b0;
                  oe_q    <= 1'b0;
                  state_q <= ST_IDLE;
                  if (read_good) begin
                     x_q     <= x_hold_q;
                     y_q     <= frm_result;
                     valid_q <= 1'b1;
                  end
               end else if (frm_done) begin
                  state_q <= ST_LEAD;
                  if (frm_ok) begin
                     retry_q  <= '0;
                     x_hold_q <= frm_result;
                     chan_y_q <= 1'b1;
                  end else begin
                     retry_q <= retry_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_req     = req_q;
   assign sif_oe      = oe_q;
   assign sif_sce     = oe_q;
   assign sif_dclk    = dclk;
   assign sif_din     = frm_din;
   assign coord_x     = x_q;
   assign coord_y     = y_q;
   assign coord_valid = valid_q;
endmodule

// File: rtl/tadc_chk.sv
`timescale 1ns/1ps
module tadc_chk import tadc_pkg::*; (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_req,
   input logic                bus_gnt,
   input logic                sif_oe,
   input logic                sif_sce,
   input logic                sif_dclk,
   input logic                sif_din,
   input logic [RES_BITS-1:0] coord_x,
   input logic [RES_BITS-1:0] coord_y,
   input logic                coord_valid,
   input logic                pen_down
);
   // R3
   no_drive_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sif_oe |-> (bus_gnt && bus_req));

   // R3
   quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sif_oe |-> (!sif_sce && !sif_dclk && !sif_din));

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coord_valid |=> !coord_valid);

   // R8
   coord_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((coord_x != $past(coord_x)) || (coord_y != $past(coord_y))) |-> coord_valid);

   // R8
   valid_ends_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coord_valid |-> (!bus_req && $past(bus_req)));

   // R2
   req_needs_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(pen_down));
endmodule

bind touch_adc_ctrl tadc_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_gnt    (bus_gnt),
   .sif_oe     (sif_oe),
   .sif_sce    (sif_sce),
   .sif_dclk   (sif_dclk),
   .sif_din    (sif_din),
   .coord_x    (coord_x),
   .coord_y    (coord_y),
   .coord_valid(coord_valid),
   .pen_down   (pen_down)
);

// File: tb/touch_adc_ctrl_tb.sv
`timescale 1ns/1ps
module touch_adc_ctrl_tb;
   localparam int         HALF_DIV  = 2;
   localparam int         RPT       = 3000;
   localparam int         RETRY     = 2;
   localparam logic [2:0] XC        = 3'b101;
   localparam logic [2:0] YC        = 3'b001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pen_irq_n = 1'b1;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic        sif_oe, sif_sce, sif_dclk, sif_din;
   logic        m_dout = 1'b0;
   logic        m_busy = 1'b0;
   logic [11:0] coord_x, coord_y;
   logic        coord_valid;

   always #5 clk = ~clk;

   touch_adc_ctrl #(
      .HALF_DIV  (HALF_DIV),
      .REPEAT_CYC(RPT),
      .MAX_RETRY (RETRY),
      .X_CH      (XC),
      .Y_CH      (YC)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pen_irq_n  (pen_irq_n),
      .bus_req    (bus_req),
      .bus_gnt    (bus_gnt),
      .sif_oe     (sif_oe),
      .sif_sce    (sif_sce),
      .sif_dclk   (sif_dclk),
      .sif_din    (sif_din),
      .adc_dout   (m_dout),
      .adc_busy   (m_busy),
      .coord_x    (coord_x),
      .coord_y    (coord_y),
      .coord_valid(coord_valid)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit gnt_en = 1'b1;

   task automatic chk(input bit cond, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // arbiter model
   always @(posedge clk) bus_gnt <= rst_n && bus_req && gnt_en;
   always @(posedge clk) cyc <= cyc + 1;

   // converter model
   logic [11:0] model_x = '0, model_y = '0, cur_val = '0;
   logic [7:0]  cbyte = '0;
   logic [2:0]  first_ch = '0, last_ch = '0;
   bit          first_seen = 1'b0;
   int          rises = 0, fail_frames = 0, frames_last = 0, sce_falls = 0, frame_rem = 0;

   always @(posedge sif_dclk) begin : m_rise
      int k;
      if (sif_sce) begin
         k = rises % 24;
         if (k < 8) cbyte = {cbyte[6:0], sif_din};
         if (k == 7) begin
            chk(cbyte[7] == 1'b1, "R4", "start bit", 32'(cbyte[7]), 1);
            chk(cbyte[3] == 1'b0, "R4", "mode bit", 32'(cbyte[3]), 0);
            chk(cbyte[2:0] == 3'b000, "R4", "ref and power bits", 32'(cbyte[2:0]), 0);
            chk(cbyte[6:4] == XC || cbyte[6:4] == YC, "R4", "channel code", 32'(cbyte[6:4]), 32'(XC));
            cur_val = (cbyte[6:4] == XC) ? model_x : model_y;
            if (!first_seen) first_ch = cbyte[6:4];
            first_seen = 1'b1;
            last_ch = cbyte[6:4];
         end
         if (k == 23 && fail_frames > 0) fail_frames--;
         rises++;
      end
   end

   always @(negedge sif_dclk) begin : m_fall
      int k;
      if (sif_sce) begin
         k = rises % 24;
         m_busy = (k == 9) && (fail_frames == 0);
         m_dout = (k >= 9 && k <= 20) ? cur_val[11-(k-9)] : 1'b0;
      end
   end

   always @(negedge sif_sce) begin
      frames_last = rises / 24;
      frame_rem   = rises % 24;
      rises       = 0;
      first_seen  = 1'b0;
      m_busy      = 1'b0;
      m_dout      = 1'b0;
      sce_falls++;
   end

   // scoreboard monitor
   logic [23:0] exp_q[$];
   int  valid_cnt = 0, last_valid_cyc = 0, pin_viol = 0;
   bit  prev_valid = 1'b0;

   always @(negedge clk) begin : mon
      logic [23:0] e;
      if (rst_n) begin
         if (!sif_oe && (sif_sce || sif_dclk || sif_din)) pin_viol++;
         if (sif_oe && (!sif_sce || !bus_gnt)) pin_viol++;
         if (prev_valid && coord_valid) chk(0, "R8", "valid longer than one cycle", 1, 0);
         if (coord_valid) begin
            valid_cnt++;
            last_valid_cyc = cyc;
            chk(!bus_req, "R8", "request low with valid", 32'(bus_req), 0);
            if (exp_q.size() == 0) begin
               chk(0, "R8", "unexpected valid", 1, 0);
            end else begin
               e = exp_q.pop_front();
               chk(coord_x == e[23:12], "R6", "x coordinate", 32'(coord_x), 32'(e[23:12]));
               chk(coord_y == e[11:0], "R6", "y coordinate", 32'(coord_y), 32'(e[11:0]));
            end
         end
         prev_valid = coord_valid;
      end
   end

   task automatic touch(input logic [11:0] x, input logic [11:0] y, input int bad,
                        input bit ok, input int exp_frames);
      int v0, s0;
      model_x = x; model_y = y; fail_frames = bad;
      if (ok) exp_q.push_back({x, y});
      v0 = valid_cnt; s0 = sce_falls;
      @(negedge clk) pen_irq_n = 1'b0;
      for (int i = 0; i < 5000 && sce_falls == s0; i++) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(valid_cnt == v0 + (ok ? 1 : 0), ok ? "R8" : "R11", "strobe count", 32'(valid_cnt - v0), 32'(ok));
      chk(frames_last == exp_frames, bad > 0 ? "R10" : "R5", "frames in grant", 32'(frames_last), 32'(exp_frames));
      chk(frame_rem == 0, "R5", "dclk edges per frame", 32'(frame_rem), 0);
      if (ok) begin
         chk(first_ch == XC, "R7", "first channel", 32'(first_ch), 32'(XC));
         chk(last_ch == YC, "R7", "last channel", 32'(last_ch), 32'(YC));
      end
      pen_irq_n = 1'b1;
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int bad, t1, t2, v0;
      logic [11:0] hx, hy;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({bus_req, sif_oe, sif_sce, sif_dclk, sif_din, coord_valid} == 6'b0, "R1", "outputs in reset",
          32'({bus_req, sif_oe, sif_sce, sif_dclk, sif_din, coord_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(coord_x == 0 && coord_y == 0 && !bus_req, "R1", "after reset", 32'({coord_x, coord_y}), 0);

      // R2 idle with pen up
      bad = 0;
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (bus_req || sif_oe) bad++;
      end
      chk(bad == 0, "R2", "activity with pen up", 32'(bad), 0);

      // R2 sync latency, R3 grant withheld
      gnt_en = 1'b0;
      model_x = 12'h3C7; model_y = 12'h81E;
      exp_q.push_back({12'h3C7, 12'h81E});
      v0 = valid_cnt;
      pen_irq_n = 1'b0;
      @(negedge clk);
      chk(!bus_req, "R2", "req one cycle after pen", 32'(bus_req), 0);
      @(negedge clk);
      chk(!bus_req, "R2", "req two cycles after pen", 32'(bus_req), 0);
      @(negedge clk);
      chk(bus_req, "R2", "req three cycles after pen", 32'(bus_req), 1);
      repeat (300) @(negedge clk);
      chk(bus_req && !sif_oe && !sif_dclk && !sif_sce, "R3", "no drive before grant",
          32'({bus_req, sif_oe, sif_dclk, sif_sce}), 32'h8);
      gnt_en = 1'b1;
      for (int i = 0; i < 2000 && valid_cnt == v0; i++) @(negedge clk);
      chk(valid_cnt == v0 + 1, "R3", "read after late grant", 32'(valid_cnt - v0), 1);
      pen_irq_n = 1'b1;
      repeat (20) @(negedge clk);

      // R6 R7 data patterns
      touch(12'h000, 12'hFFF, 0, 1'b1, 2);
      touch(12'hA5A, 12'h5A5, 0, 1'b1, 2);
      touch(12'h123, 12'hDEF, 0, 1'b1, 2);
      t1 = last_valid_cyc;
      hx = coord_x; hy = coord_y;
      repeat (100) @(negedge clk);
      chk(coord_x == hx && coord_y == hy, "R8", "coordinates held", 32'({coord_x, coord_y}), 32'({hx, hy}));

      // R9 quick release and press starts a new read early
      touch(12'h801, 12'h7FE, 0, 1'b1, 2);
      t2 = last_valid_cyc;
      chk((t2 - t1) < RPT, "R9", "re-press gap", 32'(t2 - t1), RPT);

      // R9 pen held: second read waits for the repeat interval
      model_x = 12'h456; model_y = 12'h9AB;
      exp_q.push_back({12'h456, 12'h9AB});
      exp_q.push_back({12'h456, 12'h9AB});
      v0 = valid_cnt;
      pen_irq_n = 1'b0;
      for (int i = 0; i < 2000 && valid_cnt == v0; i++) @(negedge clk);
      t1 = last_valid_cyc;
      for (int i = 0; i < 6000 && valid_cnt < v0 + 2; i++) @(negedge clk);
      t2 = last_valid_cyc;
      pen_irq_n = 1'b1;
      chk(valid_cnt == v0 + 2, "R9", "reads with pen held", 32'(valid_cnt - v0), 2);
      chk((t2 - t1) >= RPT && (t2 - t1) <= RPT + 600, "R9", "held-pen gap", 32'(t2 - t1), RPT);
      repeat (20) @(negedge clk);

      // R10 one missing busy: X rerun
      touch(12'hC3C, 12'h0F1, 1, 1'b1, 3);

      // R11 all attempts fail: abandon
      hx = coord_x; hy = coord_y;
      touch(12'h111, 12'h222, RETRY + 1, 1'b0, RETRY + 1);
      chk(coord_x == hx && coord_y == hy, "R11", "coordinates after abandon", 32'({coord_x, coord_y}), 32'({hx, hy}));
      chk(!bus_req, "R11", "request dropped", 32'(bus_req), 0);

      // recovery after abandon
      touch(12'hE07, 12'h3B9, 0, 1'b1, 2);

      chk(pin_viol == 0, "R3", "shared pin rule", 32'(pin_viol), 0);
      chk(exp_q.size() == 0, "R8", "outstanding expected reads", 32'(exp_q.size()), 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule